// File: doc/BRIEF.md
# Host Parallel Bus Interface for a Character Display Controller

This block is the host-facing side of a character display controller. A host drives an enable strobe, a read/write select, a register select and an 8-bit data bus. A transfer is framed by the enable strobe: it starts when enable goes high and is taken on its falling edge. The enable strobe is brought into the controller clock domain with a short synchronizer, and each falling edge counts as one bus event. The block routes host writes either to the command path (instruction-write strobe) or to the display-data path (data-write strobe). Either strobe comes with the assembled byte.

On reads, the block drives one of two sources. A status read returns the busy flag together with the 7-bit address counter. A data read returns a byte held in a local data register, which the core has filled ahead of time from display or pattern RAM. When a data read completes, the block pulses a read-advance strobe so that the core can move its address counter and fetch the next byte.

A narrow mode lets the host use only the upper four data lines. In this mode every byte takes two enable cycles, high half first. A half-select toggle tracks which half comes next. Reset clears the toggle, and so does leaving the narrow mode. While the core reports busy, a command write that completes is discarded.

Top module: `hbus_host_if`

## Requirements
- R1: Asynchronous active-low reset puts the block in a known state. All strobes are 0 and the output enable is 0. The half-select toggle is cleared, so the first narrow-mode access after reset is a high half.
- R2: In 8-bit mode, a write with register select 0 gives exactly one instr_wr pulse, one clock wide, with wr_byte equal to the data bus. The pulse is visible in the third clock cycle after the first rising edge that samples enable low.
- R3: A write with register select 1 gives exactly one data_wr pulse with wr_byte equal to the written byte. The busy flag has no effect on it.
- R4: When a command write completes in a cycle where busy is 1, it gives no instr_wr pulse. Busy is sampled in the cycle the synchronized falling edge is detected, not earlier.
- R5: While synchronized enable is high and read/write is 1 (a read), bus_oe is 1. In 8-bit mode with register select 0, bus_dout equals {busy, addr_cnt}: busy on bit 7, address counter on bits 6..0.
- R6: In 8-bit mode with register select 1, a read drives the data register. The data register holds the last dr_value presented with dr_load. A completed data read gives exactly one rd_adv pulse. Status reads and writes never give rd_adv, and reads never give write strobes.
- R7: In narrow mode, a write takes its high half from bus_din[7:4] in the first cycle and its low half from bus_din[7:4] in the second cycle. The write strobe fires only after the second cycle, with wr_byte = {first, second}.
- R8: In narrow mode, a read drives the selected byte's high half on bus_dout[7:4] in the first cycle and its low half in the second cycle, with bus_dout[3:0] = 0. For a data read, rd_adv fires only after the second cycle.
- R9: bus_oe is 0 while synchronized enable is low or while read/write is 0.
- R10: Reads and writes share one half-select toggle. While narrow mode is off the toggle is held clear, so re-entering narrow mode starts at the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host enable strobe; transfer taken on its falling edge |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 1 | 0 = command/status, 1 = data register |
| bus_din | input | 8 | Data bus from host |
| bus_dout | output | 8 | Data bus to host |
| bus_oe | output | 1 | Drive enable for bus_dout |
| nibble_mode | input | 1 | 1 = four-line transfers on bits 7..4 |
| busy | input | 1 | Core busy flag |
| addr_cnt | input | 7 | Core address counter |
| dr_load | input | 1 | Load strobe for the prefetched data register |
| dr_value | input | 8 | Byte fetched from RAM by the core |
| instr_wr | output | 1 | Command byte write strobe |
| data_wr | output | 1 | Data byte write strobe |
| wr_byte | output | 8 | Byte for the write strobes |
| rd_adv | output | 1 | Pulse after a completed data read |

## Verification
Two functions can meet in one cycle: a command write completing and the core's busy flag changing. The bench drops enable and then flips busy exactly in the cycle where the synchronized falling edge is detected, in both directions (1 to 0 and 0 to 1). It then counts instr_wr pulses: a write is accepted only if busy was 0 in that detection cycle. Constrained random transfers mix both bus widths, mode switches, data-register loads and busy, and are checked against a bench model of the half toggle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned HBUS_DATA_W = 8;
  localparam int unsigned HBUS_SYNC_N = 2;

  typedef enum logic [1:0] {
    STB_NONE  = 2'b00,
    STB_INSTR = 2'b01,
    STB_DATA  = 2'b10,
    STB_RDADV = 2'b11
  } hbus_stb_e;
endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_lvl,
  output logic en_fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;
  logic              last_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = en_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], en_async};
    end
  endgenerate

  always_comb last_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign en_lvl  = chain_q[STAGES-1];
  assign en_fall = last_q & ~chain_q[STAGES-1];

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !en_fall);
endmodule

// File: rtl/hbus_nibble_asm.sv
module hbus_nibble_asm #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              nib_mode,
  input  logic              rnw,
  input  logic              rs,
  input  logic              busy,
  input  logic [DATA_W-1:0] din,
  output logic              half,
  output logic              instr_wr,
  output logic              data_wr,
  output logic              rd_adv,
  output logic [DATA_W-1:0] wr_byte
);
  import hbus_pkg::*;
  localparam int unsigned NIB_W = DATA_W / 2;

  logic              half_q, half_d;
  logic [NIB_W-1:0]  hi_q, hi_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  hbus_stb_e         stb_q, stb_d;
  logic              done;
  logic [DATA_W-1:0] full_byte;

  always_comb begin
    done      = ev & (~nib_mode | half_q);
    full_byte = nib_mode ? {hi_q, din[DATA_W-1:NIB_W]} : din;

    half_d = half_q;
    if (!nib_mode)  half_d = 1'b0;
    else if (ev)    half_d = ~half_q;

    hi_d = hi_q;
    if (ev && nib_mode && !half_q && !rnw) hi_d = din[DATA_W-1:NIB_W];

    stb_d  = STB_NONE;
    byte_d = byte_q;
    if (done) begin
      if (rnw) begin
        if (rs) stb_d = STB_RDADV;
      end else if (rs) begin
        stb_d  = STB_DATA;
        byte_d = full_byte;
      end else if (!busy) begin
        stb_d  = STB_INSTR;
        byte_d = full_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hi_q   <= '0;
      byte_q <= '0;
      stb_q  <= STB_NONE;
    end else begin
      half_q <= half_d;
      hi_q   <= hi_d;
      byte_q <= byte_d;
      stb_q  <= stb_d;
    end
  end

  assign half     = half_q;
  assign instr_wr = (stb_q == STB_INSTR);
  assign data_wr  = (stb_q == STB_DATA);
  assign rd_adv   = (stb_q == STB_RDADV);
  assign wr_byte  = byte_q;

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr |-> !$past(busy));
  // R6
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_wr, data_wr, rd_adv}));
  // R7
  second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_wr || data_wr || rd_adv) && $past(nib_mode) |-> $past(half_q));
  // R10
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_mode |=> !half_q);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr |=> !instr_wr);
endmodule

// File: rtl/hbus_rd_mux.sv
module hbus_rd_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              en_lvl,
  input  logic              rnw,
  input  logic              rs,
  input  logic              nib_mode,
  input  logic              half,
  input  logic              busy,
  input  logic [DATA_W-2:0] ac,
  input  logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] src;
  logic [NIB_W-1:0]  part;

  always_comb begin
    src  = rs ? dr : {busy, ac};
    part = half ? src[NIB_W-1:0] : src[DATA_W-1:NIB_W];
    dout = nib_mode ? {part, {NIB_W{1'b0}}} : src;
    oe   = en_lvl & rnw;
  end
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if #(
  parameter int unsigned DATA_W = hbus_pkg::HBUS_DATA_W,
  parameter int unsigned SYNC_N = hbus_pkg::HBUS_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_rnw,
  input  logic              bus_rs,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic              nibble_mode,
  input  logic              busy,
  input  logic [DATA_W-2:0] addr_cnt,
  input  logic              dr_load,
  input  logic [DATA_W-1:0] dr_value,
  output logic              instr_wr,
  output logic              data_wr,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rd_adv
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic              rst_meta_q, rst_q;
  logic              en_lvl, en_fall, half;
  logic [DATA_W-1:0] dr_q, dr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  hbus_strobe_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_q), .en_async(bus_en),
    .en_lvl(en_lvl), .en_fall(en_fall)
  );

  hbus_nibble_asm #(.DATA_W(DATA_W)) asm_i (
    .clk(clk), .rst_n(rst_q), .ev(en_fall), .nib_mode(nibble_mode),
    .rnw(bus_rnw), .rs(bus_rs), .busy(busy), .din(bus_din),
    .half(half), .instr_wr(instr_wr), .data_wr(data_wr),
    .rd_adv(rd_adv), .wr_byte(wr_byte)
  );

  always_comb dr_d = dr_load ? dr_value : dr_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) dr_q <= '0;
    else        dr_q <= dr_d;
  end

  hbus_rd_mux #(.DATA_W(DATA_W)) mux_i (
    .en_lvl(en_lvl), .rnw(bus_rnw), .rs(bus_rs), .nib_mode(nibble_mode),
    .half(half), .busy(busy), .ac(addr_cnt), .dr(dr_q),
    .dout(bus_dout), .oe(bus_oe)
  );

  // R5
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_q)
    bus_oe && !bus_rs && !nibble_mode |-> bus_dout == {busy, addr_cnt});
  // R8
  nib_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    bus_oe && nibble_mode |-> bus_dout[NIB_W-1:0] == '0);
  // R9
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_rnw |-> !bus_oe);
  // R6
  no_wr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(bus_rnw) && $past(bus_rnw, 2) |-> !instr_wr && !data_wr);
endmodule

// File: tb/hbus_host_if_tb_top.sv
module hbus_host_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_rnw = 1'b0, bus_rs = 1'b0;
  logic [7:0] bus_din = '0, bus_dout;
  logic       bus_oe, nibble_mode = 1'b0, busy = 1'b0;
  logic [6:0] addr_cnt = '0;
  logic       dr_load = 1'b0;
  logic [7:0] dr_value = '0, wr_byte;
  logic       instr_wr, data_wr, rd_adv;

  int n_chk = 0, n_fail = 0;
  int mon_iw = 0, mon_dw = 0, mon_ra = 0;
  logic [7:0] mon_ib = '0, mon_db = '0;
  int exp_iw = 0, exp_dw = 0, exp_ra = 0;
  logic [7:0] exp_ib = '0, exp_db = '0, m_dr = '0;
  logic [3:0] m_hi = '0;
  logic       m_half = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  hbus_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
    .bus_rs(bus_rs), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .nibble_mode(nibble_mode), .busy(busy),
    .addr_cnt(addr_cnt), .dr_load(dr_load), .dr_value(dr_value),
    .instr_wr(instr_wr), .data_wr(data_wr), .wr_byte(wr_byte),
    .rd_adv(rd_adv)
  );

  always @(negedge clk) begin
    if (instr_wr) begin mon_iw++; mon_ib = wr_byte; end
    if (data_wr)  begin mon_dw++; mon_db = wr_byte; end
    if (rd_adv)   mon_ra++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic rs);
    logic [7:0] src;
    src = rs ? m_dr : {busy, addr_cnt};
    if (!nibble_mode) return src;
    return m_half ? {src[3:0], 4'h0} : {src[7:4], 4'h0};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", {instr_wr, data_wr, rd_adv, bus_oe}, 4'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_half = 1'b0; m_dr = '0;
  endtask

  task automatic load_dr(input logic [7:0] v);
    @(negedge clk); dr_load = 1'b1; dr_value = v;
    @(negedge clk); dr_load = 1'b0; m_dr = v;
  endtask

  task automatic xfer(input logic rnw, input logic rs, input logic [7:0] d);
    logic cmp;
    @(negedge clk);
    bus_rnw = rnw; bus_rs = rs; bus_din = d; bus_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 R9 oe while enable high", bus_oe, rnw);
    if (rnw) check(rs ? "R6 R8 data read value" : "R5 R8 status read value", bus_dout, exp_rd(rs));
    bus_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 oe after enable low", bus_oe, 1'b0);
    cmp = !nibble_mode || m_half;
    if (!rnw) begin
      if (nibble_mode && !m_half) m_hi = d[7:4];
      else if (rs) begin exp_dw++; exp_db = nibble_mode ? {m_hi, d[7:4]} : d; end
      else if (!busy) begin exp_iw++; exp_ib = nibble_mode ? {m_hi, d[7:4]} : d; end
    end else if (rs && cmp) exp_ra++;
    if (nibble_mode) m_half = ~m_half;
    check("R2 R4 R7 instr_wr count", mon_iw, exp_iw);
    check("R3 R7 data_wr count", mon_dw, exp_dw);
    check("R6 R8 rd_adv count", mon_ra, exp_ra);
    check("R2 R7 instr byte", mon_ib, exp_ib);
    check("R3 R7 data byte", mon_db, exp_db);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); nibble_mode = m;
    @(negedge clk);
    if (!m) m_half = 1'b0;
  endtask

  task automatic wr_collide(input logic b_before, input logic b_at);
    @(negedge clk);
    busy = b_before; bus_rnw = 1'b0; bus_rs = 1'b0; bus_din = 8'hC3; bus_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    @(negedge clk); busy = b_at;
    repeat (5) @(negedge clk);
    if (!b_at) begin exp_iw++; exp_ib = 8'hC3; end
    check("R4 busy sampled at edge detect", mon_iw, exp_iw);
    busy = 1'b0;
  endtask

  initial begin
    int base;
    void'($urandom(32'h1F2E3D4C));
    do_reset();
    // R1: reset state
    check("R1 idle outputs", {instr_wr, data_wr, rd_adv, bus_oe}, 4'b0);

    // R2: exact latency and width
    @(negedge clk); bus_rnw = 0; bus_rs = 0; bus_din = 8'h5A; bus_en = 1;
    repeat (4) @(negedge clk);
    bus_en = 0; base = mon_iw;
    @(negedge clk);
    @(negedge clk); check("R2 no pulse before third cycle", instr_wr, 1'b0);
    @(negedge clk); check("R2 pulse in third cycle", instr_wr, 1'b1);
    check("R2 byte on pulse", wr_byte, 8'h5A);
    @(negedge clk); check("R2 pulse width one", instr_wr, 1'b0);
    repeat (3) @(negedge clk);
    exp_iw = base + 1; exp_ib = 8'h5A;

    // R3, R4 directed
    busy = 1; xfer(0, 1, 8'hA5); xfer(0, 0, 8'h11); busy = 0;
    wr_collide(1'b0, 1'b1);
    wr_collide(1'b1, 1'b0);

    // R5, R6 reads
    addr_cnt = 7'h4F; busy = 1; xfer(1, 0, 8'h00); busy = 0;
    load_dr(8'h9C); xfer(1, 1, 8'h00);

    // R7, R8, R10 nibble
    set_mode(1);
    xfer(0, 1, 8'h70); xfer(0, 1, 8'hE0);
    load_dr(8'h3B); xfer(1, 1, 8'h00); xfer(1, 1, 8'h00);
    xfer(0, 0, 8'h20);
    set_mode(0); set_mode(1);
    xfer(1, 0, 8'h00);
    // R1: reset mid-byte clears toggle
    xfer(0, 0, 8'hF0);
    do_reset(); nibble_mode = 1'b1;
    xfer(1, 0, 8'h00);
    check("R1 toggle cleared by reset", m_half, 1'b1);
    set_mode(0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) set_mode(~nibble_mode);
      else if (r == 1) load_dr(8'($urandom));
      busy = ($urandom_range(0, 3) == 0);
      addr_cnt = 7'($urandom);
      xfer(1'($urandom), 1'($urandom), 8'($urandom));
    end
    busy = 0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule